// File: doc/BRIEF.md
# Debug Port Scan Chains

This block is the scan side of a debug port. A TAP state machine clocked by TCK walks the standard sixteen states under TMS. A 4-bit instruction register chooses which data chain sits between TDI and TDO. The chains are a 1-bit bypass, a fixed 32-bit identification word, two 35-bit access chains and a 32-bit abort chain. One access chain targets debug-port registers and the other targets access-port registers.

On the parallel side the block starts transfers. When an access chain passes through Update-DR, the block raises a one-cycle request carrying the shifted-in write data, a 2-bit register address, a read flag and a port-select bit. The request is only raised when the acknowledge captured at the start of that same scan reported OK. The registers behind the request interface supply the previous transfer's read data and acknowledge, and the block captures them at the next Capture-DR. Writing the abort chain with bit 0 set produces a one-cycle abort pulse.

Top module: `dbgport_top`

## Requirements
- R1: While TRST is low, and in Test-Logic-Reset, the instruction register holds 1110. A following DR scan of 32 bits then shifts out 0x3BA00477, LSB first: version 0x3 in bits 31:28, part 0xBA00 in bits 27:12, manufacturer 0x23B in bits 11:1, and 1 in bit 0.
- R2: Holding TMS high for five TCK rising edges from any state reaches Test-Logic-Reset, which returns the instruction to 1110.
- R3: Capture-IR loads 0001, so the first four bits shifted out of an IR scan are 1,0,0,0.
- R4: Code 1111, and every code other than 1110, 1000, 1010 and 1011, selects a 1-bit bypass stage. That stage captures 0 and delays TDI by one TCK.
- R5: Code 1010 (debug-port access) and code 1011 (access-port access) use a 35-bit chain. Capture-DR loads it with the response data in bits 34:3 and the response acknowledge in bits 2:0.
- R6: On Update-DR of code 1010, when the acknowledge captured in that scan was 010 (OK), req_valid is high for exactly one TCK. In that cycle req_wdata holds shifted bits 34:3, req_addr holds bits 2:1, req_read holds bit 0 (1 = read) and req_ap_sel is 0.
- R7: The same transfer under code 1011 carries req_ap_sel = 1.
- R8: When the captured acknowledge is anything other than 010 (for example 001, WAIT), Update-DR raises no request.
- R9: Code 1000 selects a 32-bit abort chain. Update-DR with shifted bit 0 = 1 raises abort_pulse for one TCK. With bit 0 = 0 it raises nothing, and no request is raised either way.
- R10: TDO changes only on falling TCK edges and is 0 outside Shift-IR and Shift-DR.
- R11: req_valid and abort_pulse are never high together, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| rsp_ack | input | 3 | Acknowledge of the previous transfer |
| rsp_rdata | input | 32 | Read data of the previous transfer |
| req_valid | output | 1 | One-cycle transfer request |
| req_ap_sel | output | 1 | 1 = access-port transfer, 0 = debug-port transfer |
| req_addr | output | 2 | Register address of the transfer |
| req_read | output | 1 | 1 = read request, 0 = write request |
| req_wdata | output | 32 | Write data of the transfer |
| abort_pulse | output | 1 | One-cycle abort strobe |

## Verification
The assertions assume that TMS and TDI change only away from the rising TCK edge. They also assume that rsp_ack and rsp_rdata are steady across the Capture-DR edge, and that TRST is the only asynchronous event. The bench drives TMS and TDI a short delay after each falling edge and changes the response inputs only while the TAP idles between scans. It releases TRST away from any edge and then runs a full Test-Logic-Reset walk. Each scan reads TDO after the falling edge and again after the following rising edge, which exposes any output change on the wrong edge.

// File: rtl/dbgport_pkg.sv
`timescale 1ns/1ps
package dbgport_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    CH_BYPASS, CH_IDENT, CH_DPACC, CH_APACC, CH_ABORT
  } chain_e;

  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] OP_IDENT  = 4'b1110;
  localparam logic [IR_W-1:0] OP_ABORT  = 4'b1000;
  localparam logic [IR_W-1:0] OP_DPACC  = 4'b1010;
  localparam logic [IR_W-1:0] OP_APACC  = 4'b1011;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  // Unlisted opcodes fall through to the bypass stage.
  function automatic chain_e decode_op(input logic [IR_W-1:0] op);
    case (op)
      OP_IDENT: decode_op = CH_IDENT;
      OP_ABORT: decode_op = CH_ABORT;
      OP_DPACC: decode_op = CH_DPACC;
      OP_APACC: decode_op = CH_APACC;
      default:  decode_op = CH_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/dbgport_tap.sv
`timescale 1ns/1ps
module dbgport_tap
  import dbgport_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      TS_RESET:  state_d = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   state_d = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: state_d = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: state_d = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  state_d = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: state_d = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: state_d = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: state_d = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: state_d = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: state_d = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: state_d = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  state_d = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: state_d = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: state_d = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: state_d = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: state_d = tms ? TS_SEL_DR : TS_IDLE;
      default:   state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TS_RESET;
    else        state <= state_d;
  end

  // R2: with TMS high the reset state is absorbing
  assert_reset_hold_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_RESET && tms) |=> (state == TS_RESET));

endmodule

// File: rtl/dbgport_ir.sv
`timescale 1ns/1ps
module dbgport_ir
  import dbgport_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_tdo
);

  logic [IR_W-1:0] ir_sr, ir_sr_d, ir_q_d;

  always_comb begin
    ir_sr_d = ir_sr;
    ir_q_d  = ir_q;
    case (state)
      TS_CAP_IR: ir_sr_d = IR_CAPTURE_PAT;
      TS_SH_IR:  ir_sr_d = {tdi, ir_sr[IR_W-1:1]};
      TS_UPD_IR: ir_q_d  = ir_sr;
      TS_RESET:  ir_q_d  = OP_IDENT;
      default:   ;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr <= IR_CAPTURE_PAT;
      ir_q  <= OP_IDENT;
    end else begin
      ir_sr <= ir_sr_d;
      ir_q  <= ir_q_d;
    end
  end

  assign ir_tdo = ir_sr[0];

  // R3: capture loads the fixed pattern
  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_CAP_IR) |=> (ir_sr == IR_CAPTURE_PAT));

  // R1: the reset state leaves the identification opcode in place
  assert_ir_reset_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_RESET) |=> (ir_q == OP_IDENT));

endmodule

// File: rtl/dbgport_dr.sv
`timescale 1ns/1ps
module dbgport_dr
  import dbgport_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 2,
  parameter logic [31:0] IDENT_WORD = 32'h3BA0_0477,
  localparam int         ACK_W    = ADDR_W + 1,
  localparam int         ACC_W    = DATA_W + ADDR_W + 1
) (
  input  logic              tck,
  input  logic              rst_n,
  input  tap_state_e        state,
  input  chain_e            chain,
  input  logic              tdi,
  input  logic [ACK_W-1:0]  rsp_ack,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              dr_tdo,
  output logic              req_valid,
  output logic              req_ap_sel,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_read,
  output logic [DATA_W-1:0] req_wdata,
  output logic              abort_pulse
);

  logic [ACC_W-1:0]  sr, sr_d;
  logic              ack_ok, ack_ok_d;
  logic              is_acc, req_fire, abort_fire;
  logic              req_valid_d, req_ap_sel_d, req_read_d;
  logic [ADDR_W-1:0] req_addr_d;
  logic [DATA_W-1:0] req_wdata_d;

  assign is_acc = (chain == CH_DPACC) || (chain == CH_APACC);

  // One shift register serves every chain; only the insertion point moves.
  always_comb begin
    sr_d     = sr;
    ack_ok_d = ack_ok;
    if (state == TS_CAP_DR) begin
      case (chain)
        CH_IDENT: sr_d = ACC_W'(IDENT_WORD[DATA_W-1:0]);
        CH_DPACC, CH_APACC: begin
          sr_d     = {rsp_rdata, rsp_ack};
          ack_ok_d = (rsp_ack == ACK_W'(ACK_OK));
        end
        default: sr_d = '0;
      endcase
    end else if (state == TS_SH_DR) begin
      sr_d = sr >> 1;
      case (chain)
        CH_BYPASS:          sr_d[0]        = tdi;
        CH_IDENT, CH_ABORT: sr_d[DATA_W-1] = tdi;
        default:            sr_d[ACC_W-1]  = tdi;
      endcase
    end
  end

  assign req_fire   = (state == TS_UPD_DR) && is_acc && ack_ok;
  assign abort_fire = (state == TS_UPD_DR) && (chain == CH_ABORT) && sr[0];

  always_comb begin
    req_valid_d  = req_fire;
    req_ap_sel_d = req_ap_sel;
    req_addr_d   = req_addr;
    req_read_d   = req_read;
    req_wdata_d  = req_wdata;
    if (req_fire) begin
      req_ap_sel_d = (chain == CH_APACC);
      req_wdata_d  = sr[ACC_W-1:ADDR_W+1];
      req_addr_d   = sr[ADDR_W:1];
      req_read_d   = sr[0];
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr          <= '0;
      ack_ok      <= 1'b0;
      req_valid   <= 1'b0;
      req_ap_sel  <= 1'b0;
      req_addr    <= '0;
      req_read    <= 1'b0;
      req_wdata   <= '0;
      abort_pulse <= 1'b0;
    end else begin
      sr          <= sr_d;
      ack_ok      <= ack_ok_d;
      req_valid   <= req_valid_d;
      req_ap_sel  <= req_ap_sel_d;
      req_addr    <= req_addr_d;
      req_read    <= req_read_d;
      req_wdata   <= req_wdata_d;
      abort_pulse <= abort_fire;
    end
  end

  assign dr_tdo = sr[0];

  // R6: a request lasts one cycle
  assert_req_single_R6: assert property (@(posedge tck) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R8: a request only follows an Update-DR
  assert_req_after_update_R8: assert property (@(posedge tck) disable iff (!rst_n)
    req_valid |-> $past(state == TS_UPD_DR));

  // R9: abort strobe lasts one cycle
  assert_abort_single_R9: assert property (@(posedge tck) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);

  // R11: request and abort never coincide
  assert_req_abort_excl_R11: assert property (@(posedge tck) disable iff (!rst_n)
    !(req_valid && abort_pulse));

endmodule

// File: rtl/dbgport_top.sv
`timescale 1ns/1ps
module dbgport_top
  import dbgport_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 2,
  parameter logic [31:0] IDENT_WORD = 32'h3BA0_0477,
  localparam int         ACK_W      = ADDR_W + 1
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  input  logic [ACK_W-1:0]  rsp_ack,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              req_valid,
  output logic              req_ap_sel,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_read,
  output logic [DATA_W-1:0] req_wdata,
  output logic              abort_pulse
);

  logic [1:0]      rst_sync;
  logic            rst_n;
  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  chain_e          chain;
  logic            ir_tdo, dr_tdo, tdo_d;

  // Asynchronous assertion, release aligned to TCK.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  dbgport_tap u_tap (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  dbgport_ir u_ir (
    .tck    (tck),
    .rst_n  (rst_n),
    .state  (state),
    .tdi    (tdi),
    .ir_q   (ir_q),
    .ir_tdo (ir_tdo)
  );

  assign chain = decode_op(ir_q);

  dbgport_dr #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .IDENT_WORD (IDENT_WORD)
  ) u_dr (
    .tck         (tck),
    .rst_n       (rst_n),
    .state       (state),
    .chain       (chain),
    .tdi         (tdi),
    .rsp_ack     (rsp_ack),
    .rsp_rdata   (rsp_rdata),
    .dr_tdo      (dr_tdo),
    .req_valid   (req_valid),
    .req_ap_sel  (req_ap_sel),
    .req_addr    (req_addr),
    .req_read    (req_read),
    .req_wdata   (req_wdata),
    .abort_pulse (abort_pulse)
  );

  always_comb begin
    case (state)
      TS_SH_IR: tdo_d = ir_tdo;
      TS_SH_DR: tdo_d = dr_tdo;
      default:  tdo_d = 1'b0;
    endcase
  end

  // Output retimed to the falling edge.
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) tdo <= 1'b0;
    else        tdo <= tdo_d;
  end

  // R10: TDO is quiet whenever the TAP is idle
  assert_tdo_idle_R10: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_IDLE && $past(state) == TS_IDLE) |-> (tdo == 1'b0));

endmodule

// File: tb/dbgport_top_tb.sv
`timescale 1ns/1ps
module dbgport_top_tb;

  localparam logic [31:0] EXP_IDENT = 32'h3BA0_0477;

  logic        tck, trst_n, tms, tdi, tdo;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;
  logic        req_valid, req_ap_sel, req_read, abort_pulse;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;

  int checks = 0;
  int fails = 0;
  int edge_errs = 0;
  bit done = 0;

  dbgport_top u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .req_valid(req_valid), .req_ap_sel(req_ap_sel), .req_addr(req_addr),
    .req_read(req_read), .req_wdata(req_wdata), .abort_pulse(abort_pulse)
  );

  initial tck = 1'b0;
  always #10 tck = ~tck;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Read TDO after the falling edge, drive inputs, confirm TDO held over the rising edge.
  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo; tms = m; tdi = d;
    @(posedge tck); #1;
    if (tdo !== o) edge_errs++;
  endtask

  task automatic scan(input bit ir_path, input int len, input logic [34:0] din,
                      output logic [34:0] dout);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, o);
    if (ir_path) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], o);
      dout[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
    logic [34:0] d;
    scan(1'b1, 4, {31'b0, op}, d);
    cap = d[3:0];
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
  endtask

  task automatic t_reset;
    logic [34:0] d;
    logic o;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    repeat (3) @(posedge tck);
    #5 trst_n = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    idle(2);
    check(tdo === 1'b0, "R10 tdo idle", 64'(tdo), 64'h0);
    check(req_valid === 1'b0 && abort_pulse === 1'b0, "R11 outputs quiet", 
          64'({req_valid, abort_pulse}), 64'h0);
    scan(1'b0, 32, 35'h0, d);
    check(d[31:0] === EXP_IDENT, "R1 identification after reset", 64'(d[31:0]), 64'(EXP_IDENT));
  endtask

  task automatic t_ir_capture;
    logic [3:0] c;
    load_ir(4'b1111, c);
    check(c === 4'b0001, "R3 IR capture pattern", 64'(c), 64'h1);
  endtask

  task automatic t_bypass(input logic [3:0] op);
    logic [3:0] c;
    logic [34:0] d;
    logic [7:0] pat;
    pat = 8'hA5 ^ {op, op};
    load_ir(op, c);
    scan(1'b0, 8, {27'b0, pat}, d);
    check(d[7:0] === {pat[6:0], 1'b0}, $sformatf("R4 bypass op %b", op),
          64'(d[7:0]), 64'({pat[6:0], 1'b0}));
  endtask

  task automatic t_tms_reset;
    logic [3:0] c;
    logic [34:0] d;
    logic o;
    load_ir(4'b1111, c);
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    idle(1);
    scan(1'b0, 32, 35'h0, d);
    check(d[31:0] === EXP_IDENT, "R2 five TMS-high edges restore identification",
          64'(d[31:0]), 64'(EXP_IDENT));
  endtask

  task automatic t_trst;
    logic [3:0] c;
    logic [34:0] d;
    load_ir(4'b1010, c);
    @(negedge tck); #3 trst_n = 1'b0;
    @(negedge tck); #3 trst_n = 1'b1;
    tms = 1'b0;
    idle(3);
    scan(1'b0, 32, 35'h0, d);
    check(d[31:0] === EXP_IDENT, "R1 TRST restores identification", 64'(d[31:0]), 64'(EXP_IDENT));
  endtask

  task automatic t_access(input bit ap, input logic [31:0] wd, input logic [1:0] a,
                          input logic rd, input logic [31:0] rdat);
    logic [3:0] c;
    logic [34:0] d;
    logic o;
    string rq;
    rq = ap ? "R7" : "R6";
    rsp_ack = 3'b010; rsp_rdata = rdat;
    load_ir(ap ? 4'b1011 : 4'b1010, c);
    scan(1'b0, 35, {wd, a, rd}, d);
    check(d === {rdat, 3'b010}, "R5 access capture", 64'(d), 64'({rdat, 3'b010}));
    check(req_valid === 1'b1, {rq, " request raised"}, 64'(req_valid), 64'h1);
    check(req_ap_sel === ap && req_addr === a && req_read === rd && req_wdata === wd,
          {rq, " request fields"}, {req_ap_sel, req_addr, req_read, req_wdata},
          {ap, a, rd, wd});
    step(1'b0, 1'b0, o);
    check(req_valid === 1'b0, "R11 request single cycle", 64'(req_valid), 64'h0);
  endtask

  task automatic t_wait;
    logic [3:0] c;
    logic [34:0] d;
    int seen;
    logic o;
    rsp_ack = 3'b001; rsp_rdata = 32'h0BAD_F00D;
    load_ir(4'b1010, c);
    seen = 0;
    scan(1'b0, 35, {32'h1111_2222, 2'b10, 1'b0}, d);
    if (req_valid) seen++;
    step(1'b0, 1'b0, o);
    if (req_valid) seen++;
    check(d[2:0] === 3'b001, "R5 WAIT acknowledge shifted out", 64'(d[2:0]), 64'h1);
    check(seen == 0, "R8 no request after WAIT", 64'(seen), 64'h0);
    rsp_ack = 3'b010;
  endtask

  task automatic t_abort(input logic bit0);
    logic [3:0] c;
    logic [34:0] d;
    logic o;
    load_ir(4'b1000, c);
    scan(1'b0, 32, {3'b0, 31'h7FFF_FFFF, bit0}, d);
    check(abort_pulse === bit0 && req_valid === 1'b0, "R9 abort strobe",
          64'({abort_pulse, req_valid}), 64'({bit0, 1'b0}));
    step(1'b0, 1'b0, o);
    check(abort_pulse === 1'b0, "R11 abort single cycle", 64'(abort_pulse), 64'h0);
  endtask

  initial begin
    rsp_ack = 3'b010; rsp_rdata = 32'h0;
    t_reset();
    t_ir_capture();
    t_bypass(4'b1111);
    t_bypass(4'b0000);
    t_bypass(4'b0001);
    t_bypass(4'b1100);
    t_tms_reset();
    t_trst();
    t_access(1'b0, 32'h1234_5678, 2'b01, 1'b0, 32'hCAFE_F00D);
    t_access(1'b1, 32'h89AB_CDEF, 2'b11, 1'b1, 32'h5555_AAAA);
    t_wait();
    t_abort(1'b1);
    t_abort(1'b0);
    check(edge_errs == 0, "R10 TDO steady across rising edges", 64'(edge_errs), 64'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule